// File: doc/BRIEF.md
# Interrupt Pending and Cause Register Unit

This unit gathers single-cycle fault and event pulses from the rest of the terminal and turns them into one level interrupt for the host. The sources are:

- a RAM initialization mismatch;
- an uncorrectable memory data error;
- a loopback failure on each bus;
- a time-tag counter wrap.

Each source owns one bit in a sticky pending register. A bit is captured only while the matching interrupt-enable bit is set. A second mask, the output-enable register, decides which captured bits may drive the interrupt pin.

The RAM initialization mismatch and the uncorrectable memory error share a single pending bit. A separate cause flag tells them apart: an initialization mismatch sets the flag and an uncorrectable error clears it. After the host sees the shared bit, it reads the flag to learn which fault happened. Both enable masks come out of reset with the shared memory-fault bit already enabled, so that an early memory fault is reported before any software setup.

The host reaches the unit through a small read/write port. Reads are combinational from the selected register. A write of 1 to a pending bit clears that bit.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the pending register and the cause flag read 0, the interrupt-enable and output-enable registers read 0x0001, and `irqOut` is low.
- R2: The host address selects the register: 0 is pending, 1 is interrupt-enable, 2 is output-enable, 3 is cause status. The source bits, from bit 0 upward, are:
  - bit 0: the memory fault;
  - bits 1 to NUM_BUS: loopback failure for bus index 0 upward (bit 1 is bus A, bit 2 is bus B);
  - bit NUM_BUS+1: the time-tag wrap.

  Both enable registers read back the value last written into their implemented bits, and all other bits read 0.
- R3: A source pulse while its interrupt-enable bit is 1 sets its pending bit at that clock edge. A pulse while the enable bit is 0 leaves the pending bit unchanged.
- R4: An initialization-mismatch pulse sets the cause flag (bit 0 at address 3), and an uncorrectable-error pulse clears it. When both pulse together, the flag is set. Either pulse sets pending bit 0 when that bit is enabled. The flag follows these pulses whatever the enables hold.
- R5: A pending bit stays set until the host writes a 1 to it. Writing 0 to it has no effect, and writes to the cause status address change nothing.
- R6: When a source pulse and a host clear of the same pending bit fall in the same cycle, the pulse wins and the bit stays set.
- R7: `irqOut` is high exactly when some pending bit and its output-enable bit are both 1. It follows the registers without an extra cycle of delay.
- R8: Clearing an interrupt-enable bit does not clear a pending bit that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| hostAddr | input | 2 | Register select |
| hostWr | input | 1 | Write strobe |
| hostWrData | input | DATA_W | Write data |
| hostRdData | output | DATA_W | Read data of the selected register |
| evtInitFail | input | 1 | RAM initialization mismatch pulse |
| evtUncorr | input | 1 | Uncorrectable memory error pulse |
| evtLoopFail | input | NUM_BUS | Loopback failure pulse, one per bus |
| evtRollover | input | 1 | Time-tag counter wrap pulse |
| irqOut | output | 1 | Interrupt output, active high |

## Verification
The bench builds the unit with its defaults: NUM_BUS = 2 and DATA_W = 16. This gives four source bits, so random writes and pulses cover every combination of the pending, enable and output-enable masks. The twelve unused upper data bits stay observable, so writes into them can be shown to have no effect. Random cycles with pulses and clears landing together reach the clear-versus-set collision and the simultaneous initialization and uncorrectable pulse. Directed sequences pin down the reset values and the sticky behaviour.

// File: rtl/irq_status_pkg.sv
`timescale 1ns/1ps
package irq_status_pkg;

  // Register select, decoded from the host address
  typedef enum logic [1:0] {
    REG_PEND  = 2'd0,
    REG_EN    = 2'd1,
    REG_OUTEN = 2'd2,
    REG_STAT  = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    clrPend;
    logic    ldEn;
    logic    ldOutEn;
    regSel_e rdSel;
  } hostStrobe_t;

endpackage

// File: rtl/irq_status_ctrl.sv
`timescale 1ns/1ps
module irq_status_ctrl
  import irq_status_pkg::*;
(
  input  logic [1:0]  hostAddr,
  input  logic        hostWr,
  output hostStrobe_t strobe
);

  regSel_e sel;

  always_comb begin
    sel            = regSel_e'(hostAddr);
    strobe.rdSel   = sel;
    strobe.clrPend = hostWr && (sel == REG_PEND);
    strobe.ldEn    = hostWr && (sel == REG_EN);
    strobe.ldOutEn = hostWr && (sel == REG_OUTEN);
  end

endmodule

// File: rtl/irq_status_dp.sv
`timescale 1ns/1ps
module irq_status_dp
  import irq_status_pkg::*;
#(
  parameter int unsigned NUM_BUS = 2,
  parameter int unsigned DATA_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  hostStrobe_t               strobe,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      evtInitFail,
  input  logic                      evtUncorr,
  input  logic [NUM_BUS-1:0]        evtLoopFail,
  input  logic                      evtRollover,
  output logic [DATA_W-1:0]         rdData,
  output logic                      irqOut,
  output logic [NUM_BUS+1:0]        pendVec,
  output logic [NUM_BUS+1:0]        enVec,
  output logic [NUM_BUS+1:0]        outEnVec,
  output logic                      statusBit
);

  localparam int unsigned NUM_SRC = NUM_BUS + 2;
  localparam int unsigned ROLL_IDX = NUM_BUS + 1;
  localparam logic [NUM_SRC-1:0] EN_RST = NUM_SRC'(1);

  logic [NUM_SRC-1:0] evtVec;
  logic [NUM_SRC-1:0] pendReg;
  logic [NUM_SRC-1:0] enReg;
  logic [NUM_SRC-1:0] outEnReg;
  logic               statusReg;
  logic               unusedWrBits;

  assign unusedWrBits = ^wrData[DATA_W-1:NUM_SRC];

  // Map each source onto its pending bit
  assign evtVec[0]        = evtInitFail | evtUncorr;
  assign evtVec[ROLL_IDX] = evtRollover;
  for (genvar b = 0; b < NUM_BUS; b++) begin : g_loopMap
    assign evtVec[b+1] = evtLoopFail[b];
  end

  // One sticky bit per source. A pulse overrides a clear in the same cycle.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendReg[i] <= 1'b0;
      end else if (evtVec[i] && enReg[i]) begin
        pendReg[i] <= 1'b1;
      end else if (strobe.clrPend && wrData[i]) begin
        pendReg[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= EN_RST;
      outEnReg <= EN_RST;
    end else begin
      if (strobe.ldEn)    enReg    <= wrData[NUM_SRC-1:0];
      if (strobe.ldOutEn) outEnReg <= wrData[NUM_SRC-1:0];
    end
  end

  // Cause flag: an init mismatch sets it and wins over an uncorrectable error
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= 1'b0;
    end else if (evtInitFail) begin
      statusReg <= 1'b1;
    end else if (evtUncorr) begin
      statusReg <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      REG_PEND:  rdData[NUM_SRC-1:0] = pendReg;
      REG_EN:    rdData[NUM_SRC-1:0] = enReg;
      REG_OUTEN: rdData[NUM_SRC-1:0] = outEnReg;
      REG_STAT:  rdData[0]           = statusReg;
    endcase
  end

  assign irqOut    = |(pendReg & outEnReg);
  assign pendVec   = pendReg;
  assign enVec     = enReg;
  assign outEnVec  = outEnReg;
  assign statusBit = statusReg;

endmodule

// File: rtl/irq_status_unit.sv
`timescale 1ns/1ps
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int unsigned NUM_BUS = 2,
  parameter int unsigned DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         hostAddr,
  input  logic               hostWr,
  input  logic [DATA_W-1:0]  hostWrData,
  output logic [DATA_W-1:0]  hostRdData,
  input  logic               evtInitFail,
  input  logic               evtUncorr,
  input  logic [NUM_BUS-1:0] evtLoopFail,
  input  logic               evtRollover,
  output logic               irqOut
);

  hostStrobe_t        strobe;
  logic [NUM_BUS+1:0] pendVec;
  logic [NUM_BUS+1:0] enVec;
  logic [NUM_BUS+1:0] outEnVec;
  logic               statusBit;

  irq_status_ctrl u_ctrl (
    .hostAddr (hostAddr),
    .hostWr   (hostWr),
    .strobe   (strobe)
  );

  irq_status_dp #(
    .NUM_BUS (NUM_BUS),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (hostWrData),
    .evtInitFail (evtInitFail),
    .evtUncorr   (evtUncorr),
    .evtLoopFail (evtLoopFail),
    .evtRollover (evtRollover),
    .rdData      (hostRdData),
    .irqOut      (irqOut),
    .pendVec     (pendVec),
    .enVec       (enVec),
    .outEnVec    (outEnVec),
    .statusBit   (statusBit)
  );

endmodule

// File: rtl/irq_status_chk.sv
`timescale 1ns/1ps
module irq_status_chk #(
  parameter int unsigned NUM_BUS = 2,
  parameter int unsigned DATA_W  = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         hostAddr,
  input logic               hostWr,
  input logic [DATA_W-1:0]  hostWrData,
  input logic               evtInitFail,
  input logic               evtUncorr,
  input logic [NUM_BUS-1:0] evtLoopFail,
  input logic               evtRollover,
  input logic               irqOut,
  input logic [NUM_BUS+1:0] pendVec,
  input logic [NUM_BUS+1:0] enVec,
  input logic [NUM_BUS+1:0] outEnVec,
  input logic               statusBit
);

  localparam int unsigned NUM_SRC = NUM_BUS + 2;

  logic [NUM_SRC-1:0] srcVec;
  logic               pendWr;

  assign srcVec = {evtRollover, evtLoopFail, evtInitFail | evtUncorr};
  assign pendWr = hostWr && (hostAddr == 2'd0);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
      (srcVec[i] && enVec[i]) |=> pendVec[i]); // R3

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
      (!pendVec[i] && !(srcVec[i] && enVec[i])) |=> !pendVec[i]); // R3

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (pendVec[i] && !(pendWr && hostWrData[i])) |=> pendVec[i]); // R5
  end

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((|pendVec) && (|outEnVec))); // R7

  AST_INIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    evtInitFail |=> statusBit); // R4

  AST_UNCORR_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (evtUncorr && !evtInitFail) |=> !statusBit); // R4

endmodule

bind irq_status_unit irq_status_chk #(
  .NUM_BUS (NUM_BUS),
  .DATA_W  (DATA_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hostAddr    (hostAddr),
  .hostWr      (hostWr),
  .hostWrData  (hostWrData),
  .evtInitFail (evtInitFail),
  .evtUncorr   (evtUncorr),
  .evtLoopFail (evtLoopFail),
  .evtRollover (evtRollover),
  .irqOut      (irqOut),
  .pendVec     (pendVec),
  .enVec       (enVec),
  .outEnVec    (outEnVec),
  .statusBit   (statusBit)
);

// File: tb/test_irq_status_unit.sv
`timescale 1ns/1ps
module test_irq_status_unit;

  localparam int unsigned NUM_BUS = 2;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned NUM_SRC = NUM_BUS + 2;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [1:0]         hostAddr = '0;
  logic               hostWr = 1'b0;
  logic [DATA_W-1:0]  hostWrData = '0;
  logic [DATA_W-1:0]  hostRdData;
  logic               evtInitFail = 1'b0;
  logic               evtUncorr = 1'b0;
  logic [NUM_BUS-1:0] evtLoopFail = '0;
  logic               evtRollover = 1'b0;
  logic               irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model of the registers
  logic [NUM_SRC-1:0] mPend, mEn, mOutEn;
  logic               mStat;

  always #2.5 clk = ~clk;

  irq_status_unit #(.NUM_BUS(NUM_BUS), .DATA_W(DATA_W)) i_irq_status_unit (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .evtInitFail(evtInitFail), .evtUncorr(evtUncorr),
    .evtLoopFail(evtLoopFail), .evtRollover(evtRollover), .irqOut(irqOut)
  );

  function automatic logic [NUM_SRC-1:0] nextPend(
    input logic [NUM_SRC-1:0] pend, input logic [NUM_SRC-1:0] en,
    input logic [NUM_SRC-1:0] src, input logic [NUM_SRC-1:0] clr);
    return (pend & ~clr) | (src & en);
  endfunction

  function automatic logic nextStat(input logic cur, input logic ini, input logic unc);
    return ini ? 1'b1 : (unc ? 1'b0 : cur);
  endfunction

  task automatic chk(input string tag, input string what, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
    hostAddr = a;
    #0.2;
    d = hostRdData;
  endtask

  task automatic checkAll(input string tag);
    logic [DATA_W-1:0] d;
    rd(2'd0, d); chk(tag, "pending", d, DATA_W'(mPend));
    rd(2'd1, d); chk(tag, "enable", d, DATA_W'(mEn));
    rd(2'd2, d); chk(tag, "outEnable", d, DATA_W'(mOutEn));
    rd(2'd3, d); chk(tag, "status", d, DATA_W'(mStat));
    chk(tag, "irqOut", DATA_W'(irqOut), DATA_W'(|(mPend & mOutEn)));
  endtask

  // One clock with the given host access and pulses, then model update and checks
  task automatic cyc(input logic wr, input logic [1:0] a, input logic [DATA_W-1:0] d,
                     input logic ini, input logic unc, input logic [NUM_BUS-1:0] lp,
                     input logic roll, input string tag);
    logic [NUM_SRC-1:0] src, clr;
    @(negedge clk);
    hostWr = wr; hostAddr = a; hostWrData = d;
    evtInitFail = ini; evtUncorr = unc; evtLoopFail = lp; evtRollover = roll;
    @(posedge clk);
    src = {roll, lp, ini | unc};
    clr = (wr && a == 2'd0) ? d[NUM_SRC-1:0] : '0;
    mPend = nextPend(mPend, mEn, src, clr);
    mStat = nextStat(mStat, ini, unc);
    if (wr && a == 2'd1) mEn = d[NUM_SRC-1:0];
    if (wr && a == 2'd2) mOutEn = d[NUM_SRC-1:0];
    #1;
    hostWr = 1'b0; evtInitFail = 1'b0; evtUncorr = 1'b0; evtLoopFail = '0; evtRollover = 1'b0;
    checkAll(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    void'($urandom(32'h5A17));
    mPend = '0; mEn = NUM_SRC'(1); mOutEn = NUM_SRC'(1); mStat = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #0.5;
    // R1: reset values
    rd(2'd0, d); chk("R1", "pending reset", d, 16'h0000);
    rd(2'd1, d); chk("R1", "enable reset", d, 16'h0001);
    rd(2'd2, d); chk("R1", "outEnable reset", d, 16'h0001);
    rd(2'd3, d); chk("R1", "status reset", d, 16'h0000);
    chk("R1", "irqOut reset", DATA_W'(irqOut), 16'h0);

    // R2: upper bits read 0 after writing all ones
    cyc(1, 2'd1, 16'hFFFF, 0, 0, '0, 0, "R2");
    rd(2'd1, d); chk("R2", "enable upper bits", d, 16'h000F);
    cyc(1, 2'd2, 16'h0000, 0, 0, '0, 0, "R2");

    // R3: loopback bus A sets bit 1
    cyc(0, 2'd0, 16'h0, 0, 0, 2'b01, 0, "R3");
    rd(2'd0, d); chk("R3", "loopA pending", d, 16'h0002);
    // R7: irq follows outEnable immediately
    chk("R7", "irq masked", DATA_W'(irqOut), 16'h0);
    cyc(1, 2'd2, 16'h0002, 0, 0, '0, 0, "R7");
    chk("R7", "irq unmasked", DATA_W'(irqOut), 16'h1);

    // R5: writing 0 and writing status leave state alone
    cyc(1, 2'd0, 16'h0000, 0, 0, '0, 0, "R5");
    cyc(1, 2'd3, 16'hFFFF, 0, 0, '0, 0, "R5");
    rd(2'd0, d); chk("R5", "pending kept", d, 16'h0002);
    rd(2'd3, d); chk("R5", "status unchanged", d, 16'h0000);

    // R6: clear collides with a new pulse
    cyc(1, 2'd0, 16'h0002, 0, 0, 2'b01, 0, "R6");
    rd(2'd0, d); chk("R6", "pulse beats clear", d, 16'h0002);
    cyc(1, 2'd0, 16'h0002, 0, 0, '0, 0, "R5");
    rd(2'd0, d); chk("R5", "cleared by write 1", d, 16'h0000);

    // R4: cause flag
    cyc(0, 2'd0, 16'h0, 1, 0, '0, 0, "R4");
    rd(2'd3, d); chk("R4", "init sets flag", d, 16'h0001);
    rd(2'd0, d); chk("R4", "shared pending", d, 16'h0001);
    cyc(0, 2'd0, 16'h0, 0, 1, '0, 0, "R4");
    rd(2'd3, d); chk("R4", "uncorr clears flag", d, 16'h0000);
    cyc(0, 2'd0, 16'h0, 1, 1, '0, 0, "R4");
    rd(2'd3, d); chk("R4", "both pulses set flag", d, 16'h0001);

    // R8: disabling keeps pending; R3: disabled source ignored
    cyc(0, 2'd0, 16'h0, 0, 0, '0, 1, "R3");
    cyc(1, 2'd1, 16'h0000, 0, 0, '0, 0, "R8");
    rd(2'd0, d); chk("R8", "pending kept after disable", d, 16'h0009);
    cyc(0, 2'd0, 16'h0, 0, 0, 2'b10, 0, "R3");
    rd(2'd0, d); chk("R3", "disabled loopB ignored", d, 16'h0009);
    cyc(0, 2'd0, 16'h0, 0, 1, '0, 0, "R4");
    rd(2'd3, d); chk("R4", "flag follows with enable 0", d, 16'h0000);

    // Random traffic against the model
    for (int n = 0; n < 2000; n++) begin
      logic wr;
      wr = ($urandom % 4) == 0;
      cyc(wr, 2'($urandom), 16'($urandom), ($urandom % 5) == 0, ($urandom % 5) == 0,
          NUM_BUS'($urandom & $urandom), ($urandom % 4) == 0, "R3/R5/R6/R7");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule